// File: doc/BRIEF.md
# Dual-Compare Output Pulse Generator

This block is one output compare channel driven by a free-running time base. It holds two 16-bit compare values, a leading value and a trailing value, and compares them against one of two up-counting timers. The channel output goes high on a leading-value match and low on a trailing-value match. Each trailing match also sets an event flag. When the interrupt enable is set, that flag raises an interrupt request.

Two pulse modes exist. In one-shot mode the channel emits a single pulse and then stays idle. Writing the one-shot mode code again arms it for another pulse, and the channel does not have to be turned off first. In repeating mode the channel emits one pulse and sets one flag in every period of the selected timer. Each timer has a period register and wraps to zero after it reaches that value. Each timer also has a run bit and a count-clear bit.

Software reaches every register through a plain write port: a strobe, a 3-bit address and 16 bits of data. A write is accepted in the same cycle it is presented. There is no back-pressure.

Top module: `ocp_channel`

## Requirements
- R1: After reset the output, the flag and the interrupt request are 0. Both timers hold 0 and are stopped. The mode is 000.
- R2: Control register (address 0) bits [2:0] select the mode: 100 is one-shot, 101 is repeating. Any other value keeps the output low and produces no flag events.
- R3: A control write forces the output low from the next cycle on. No compare action is taken at that edge.
- R4: A clock edge at which the selected timer equals the leading value (address 1) drives the output high from the next cycle.
- R5: A clock edge at which the selected timer equals the trailing value (address 2) drives the output low and sets the flag. When both values match at the same edge, the trailing action wins and no pulse appears.
- R6: In one-shot mode, after the trailing match no further rising edges or flag events occur until the control register is written again.
- R7: A running timer that equals its period register (address 3 for timer 0, address 4 for timer 1) goes to 0 at the next edge. In repeating mode, any window of N·(period+1) running cycles holds exactly N rising edges.
- R8: Control bit 3 selects timer 1 (1) or timer 0 (0). A timer counts only while its run bit is 1. The run bit is bit 0 at address 5 for timer 0 and address 6 for timer 1. Bit 1 at the same address clears the count to 0.
- R9: A compare match is acted on once for each new timer value. A stopped timer does not trigger again. A count that is stopped at a match value since before the last control write triggers nothing.
- R10: Writing the control register with bit 5 = 0 clears the flag, and bit 5 = 1 keeps it. The interrupt request is flag AND control bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| pin_out | output | 1 | Channel output |
| flag_out | output | 1 | Trailing-match event flag |
| irq_out | output | 1 | Interrupt request (flag gated by enable) |

## Verification
The hardest case to reach from the ports is a match on a stopped timer. The count must sit exactly on a compare value while the channel is re-armed, and then it must be shown that no edge follows until the timer runs again. The stimulus reaches this deterministically. It clears and stops timer 1, sets the leading value to 0, and arms one-shot mode. It then checks that the output stays low, and restarts the timer to show the pulse does appear. Random register writes then hit wraps, timer swaps and mid-pulse re-arms against a cycle model.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int TW = 16;
  localparam int NT = 2;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_LEAD = 3'd1;
  localparam logic [AW-1:0] A_TRAIL = 3'd2;
  localparam logic [AW-1:0] A_PER_BASE = 3'd3;
  localparam logic [AW-1:0] A_TCTL_BASE = 3'd5;
  localparam logic [2:0] M_ONESHOT = 3'b100;
  localparam logic [2:0] M_REPEAT = 3'b101;
endpackage

// File: rtl/ocp_timebase.sv
module ocp_timebase
  import ocp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_wr,
  input  logic          ctl_wr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] cnt,
  output logic          fresh
);
  logic [TW-1:0] per_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q <= '0;
      run_q <= 1'b0;
      cnt   <= '0;
      fresh <= 1'b1;
    end else begin
      if (per_wr) per_q <= wdata;
      if (ctl_wr) run_q <= wdata[0];
      if (ctl_wr && wdata[1]) begin
        cnt   <= '0;
        fresh <= 1'b1;
      end else begin
        fresh <= run_q;
        if (run_q) cnt <= (cnt == per_q) ? '0 : cnt + 1'b1;
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(ctl_wr && wdata[1])) |=> $stable(cnt));
  // R7
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt == per_q && !ctl_wr) |=> (cnt == '0));
endmodule

// File: rtl/ocp_compare.sv
module ocp_compare
  import ocp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr,
  input  logic                  lead_wr,
  input  logic                  trail_wr,
  input  logic [TW-1:0]         wdata,
  input  logic [NT-1:0][TW-1:0] tmr_vec,
  input  logic [NT-1:0]         fresh_vec,
  output logic                  pin,
  output logic                  flag,
  output logic                  irq
);
  logic [TW-1:0] lead_q, trail_q;
  logic [2:0]    mode_q;
  logic          sel_q, ie_q, done_q;
  logic [TW-1:0] tb_cnt;
  logic          tb_fresh, pulse_mode, armed, lead_hit, trail_hit;

  assign tb_cnt     = tmr_vec[sel_q];
  assign tb_fresh   = fresh_vec[sel_q];
  assign pulse_mode = (mode_q == M_ONESHOT) || (mode_q == M_REPEAT);
  assign armed      = pulse_mode && !done_q && tb_fresh;
  assign trail_hit  = armed && (tb_cnt == trail_q);
  assign lead_hit   = armed && (tb_cnt == lead_q);
  assign irq        = flag & ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_q <= '0; trail_q <= '0; mode_q <= '0;
      sel_q <= 1'b0; ie_q <= 1'b0; done_q <= 1'b0;
      pin <= 1'b0; flag <= 1'b0;
    end else begin
      if (lead_wr)  lead_q  <= wdata;
      if (trail_wr) trail_q <= wdata;
      if (ctl_wr) begin
        mode_q <= wdata[2:0];
        sel_q  <= wdata[3];
        ie_q   <= wdata[4];
        flag   <= flag & wdata[5];
        pin    <= 1'b0;
        done_q <= 1'b0;
      end else if (trail_hit) begin
        pin  <= 1'b0;
        flag <= 1'b1;
        if (mode_q == M_ONESHOT) done_q <= 1'b1;
      end else if (lead_hit) begin
        pin <= 1'b1;
      end
    end
  end

  // R3
  ctl_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !pin);
  // R4
  rise_on_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin) |-> $past(tb_cnt == lead_q));
  // R5
  flag_on_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tb_cnt == trail_q));
  // R2
  idle_mode_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && !ctl_wr) |=> !pin);
endmodule

// File: rtl/ocp_channel.sv
module ocp_channel
  import ocp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  output logic          pin_out,
  output logic          flag_out,
  output logic          irq_out
);
  logic [NT-1:0][TW-1:0] tmr_vec;
  logic [NT-1:0]         fresh_vec;

  for (genvar i = 0; i < NT; i++) begin : g_tb
    localparam logic [AW-1:0] PER_A = A_PER_BASE + AW'(i);
    localparam logic [AW-1:0] CTL_A = A_TCTL_BASE + AW'(i);
    ocp_timebase u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .per_wr (wr_en && wr_addr == PER_A),
      .ctl_wr (wr_en && wr_addr == CTL_A),
      .wdata  (wr_data),
      .cnt    (tmr_vec[i]),
      .fresh  (fresh_vec[i])
    );
  end

  ocp_compare u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (wr_en && wr_addr == A_CTRL),
    .lead_wr   (wr_en && wr_addr == A_LEAD),
    .trail_wr  (wr_en && wr_addr == A_TRAIL),
    .wdata     (wr_data),
    .tmr_vec   (tmr_vec),
    .fresh_vec (fresh_vec),
    .pin       (pin_out),
    .flag      (flag_out),
    .irq       (irq_out)
  );
endmodule

// File: tb/sim_ocp_channel.sv
module sim_ocp_channel;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pin_out, flag_out, irq_out;
  int n_chk = 0, n_bad = 0;
  int rises = 0, highs = 0;
  logic prev_pin = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ocp_channel u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .pin_out(pin_out), .flag_out(flag_out),
                  .irq_out(irq_out));

  // reference model state
  logic [15:0] m_t [2], m_per [2];
  logic m_run [2], m_fr [2];
  logic [15:0] m_lead, m_trail;
  logic [2:0] m_mode;
  logic m_sel, m_ie, m_flag, m_pin, m_done;

  function automatic bit is_pulse(input logic [2:0] m);
    return m == 3'b100 || m == 3'b101;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_t[i] = '0; m_per[i] = '0; m_run[i] = 0; m_fr[i] = 1;
      end
      m_lead = '0; m_trail = '0; m_mode = '0; m_sel = 0; m_ie = 0;
      m_flag = 0; m_pin = 0; m_done = 0;
    end else begin
      logic arm;
      logic [15:0] tv;
      tv  = m_t[m_sel];
      arm = is_pulse(m_mode) && !m_done && m_fr[m_sel];
      if (wr_en && wr_addr == 3'd0) begin
        m_pin = 0; m_done = 0; m_flag = m_flag & wr_data[5];
      end else if (arm && tv == m_trail) begin
        m_pin = 0; m_flag = 1; if (m_mode == 3'b100) m_done = 1;
      end else if (arm && tv == m_lead) m_pin = 1;
      for (int i = 0; i < 2; i++) begin
        logic wr_t;
        wr_t = wr_en && wr_addr == 3'(5 + i);
        if (wr_t && wr_data[1]) begin
          m_t[i] = '0; m_fr[i] = 1;
        end else begin
          m_fr[i] = m_run[i];
          if (m_run[i]) m_t[i] = (m_t[i] == m_per[i]) ? '0 : m_t[i] + 1'b1;
        end
        if (wr_t) m_run[i] = wr_data[0];
        if (wr_en && wr_addr == 3'(3 + i)) m_per[i] = wr_data;
      end
      if (wr_en && wr_addr == 3'd0) begin
        m_mode = wr_data[2:0]; m_sel = wr_data[3]; m_ie = wr_data[4];
      end
      if (wr_en && wr_addr == 3'd1) m_lead = wr_data;
      if (wr_en && wr_addr == 3'd2) m_trail = wr_data;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 R5 R6 model pin", pin_out, m_pin);
      chk("R5 model flag", flag_out, m_flag);
      chk("R10 model irq", irq_out, m_flag & m_ie);
      if (pin_out && !prev_pin) rises++;
      if (pin_out) highs++;
    end
    prev_pin = pin_out;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin", pin_out, 0); chk("R1 flag", flag_out, 0); chk("R1 irq", irq_out, 0);

    // R6 one-shot: lead 3, trail 6, period 9
    wr(3'd1, 16'd3); wr(3'd2, 16'd6); wr(3'd3, 16'd9);
    wr(3'd0, 16'h0014);
    wr(3'd5, 16'h0003);
    rises = 0; highs = 0; idle(40);
    chk("R6 one-shot rises", rises, 1);
    chk("R4 one-shot width", highs, 3);
    chk("R5 flag set", flag_out, 1);
    chk("R10 irq", irq_out, 1);

    // R10 clear flag while switching to repeating mode
    wr(3'd0, 16'h0015);
    chk("R10 flag cleared", flag_out, 0);
    idle(12);
    rises = 0; highs = 0; idle(50);
    chk("R7 repeat rises", rises, 5);
    chk("R7 repeat width", highs, 15);

    // R5 equal compare values: no pulse, flag still set
    wr(3'd1, 16'd4); wr(3'd2, 16'd4);
    wr(3'd0, 16'h0005);
    rises = 0; idle(30);
    chk("R5 equal rises", rises, 0);
    chk("R5 equal flag", flag_out, 1);

    // R2 non-pulse mode
    wr(3'd1, 16'd2); wr(3'd2, 16'd7);
    wr(3'd0, 16'h0002);
    rises = 0; idle(30);
    chk("R2 idle rises", rises, 0);
    chk("R2 idle flag", flag_out, 0);

    // R9 stalled timer 1 at lead value 0, then R8 select and run
    wr(3'd4, 16'd100);
    wr(3'd6, 16'h0002);
    wr(3'd1, 16'd0); wr(3'd2, 16'd5);
    wr(3'd0, 16'h000C);
    rises = 0; idle(10);
    chk("R9 stalled no rise", rises, 0);
    wr(3'd6, 16'h0003);
    idle(2);
    chk("R8 timer1 pulse", pin_out, 1);
    idle(10);
    chk("R8 timer1 trailing", pin_out, 0);
    chk("R3 R5 flag after timer1", flag_out, 1);

    // R3 mid-pulse re-arm forces low
    wr(3'd6, 16'h0003);
    idle(2);
    wr(3'd0, 16'h002C);
    chk("R3 forced low", pin_out, 0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 9) == 0) begin
        logic [2:0] a;
        logic [15:0] d;
        a = 3'($urandom_range(0, 6));
        case (a)
          3'd0: d = {10'd0, 1'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom_range(0, 3) != 0) ? 3'b10 + 3'($urandom_range(0, 1)) * 0 + 3'($urandom_range(4, 5)) - 3'b10
                                                : 3'($urandom)};
          3'd5, 3'd6: d = {14'd0, ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) != 0)};
          default: d = 16'($urandom_range(0, 20));
        endcase
        wr(a, d);
      end else idle(1);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule